// File: doc/BRIEF.md
# Single-Outstanding DMA Transaction Controller

This block sits between a local DMA sequencer and the memory directory. It accepts one load or store request at a time from the sequencer. It turns each accepted request into a single read or write message toward the directory, and the message leaves through a fixed-latency issue pipeline. It then holds until the one response that matches the open transaction arrives. A returned data block goes back to the sequencer as a one-cycle data strobe, and a completed write goes back as a one-cycle acknowledge strobe.

The controller tracks read and write in separate busy states. A response counts only when its type fits the busy state the controller is in. Any other response, and any request whose type code is neither load nor store, is absorbed without a state change and raises a sticky error flag. Each outgoing message carries both addresses, the data block and the length from the request. The controller adds its own requester identity and a directory index taken from a configurable slice of the line address.

Top module: `dma_txn_ctrl`

## Requirements
- R1: After reset the controller is idle. `req_ready` is 1, and `dir_valid`, `seq_data_valid`, `seq_ack`, `err_req` and `err_rsp` are all 0.
- R2: When idle, a request with `req_kind`=2'b00 (load) is consumed. After exactly ISSUE_LAT clock edges, counting the accepting edge as the first, `dir_valid` is high for one cycle with `dir_kind`=0 (read). The message copies paddr, laddr, data and len from the request, carries `dir_src`=REQ_ID and `dir_dest`=laddr[DIR_LSB +: DEST_W].
- R3: When idle, a request with `req_kind`=2'b01 (store) produces the same kind of message with `dir_kind`=1 (write) and the same field copying and timing.
- R4: While a read or write is open, or while a message is still in the issue pipeline, `req_ready` is 0. A request held during that time is not consumed and never produces a directory message.
- R5: With a read open, a response with `rsp_kind`=2'b01 (data) closes the transaction. On the next cycle `seq_data_valid` pulses for one cycle with `seq_data` equal to the response data, and `req_ready` returns to 1.
- R6: With a write open, a response with `rsp_kind`=2'b10 (acknowledge) closes the transaction. On the next cycle `seq_ack` pulses for one cycle, and `req_ready` returns to 1.
- R7: A response arriving when idle, an acknowledge with a read open, a data response with a write open, or a response with `rsp_kind`=2'b00 or 2'b11 sets `err_rsp`. The flag stays set until reset. No strobe reaches the sequencer and the state does not change.
- R8: When idle, a request with `req_kind`=2'b10 or 2'b11 is consumed and sets `err_req`, which stays set until reset. No directory message is produced and the controller stays idle.
- R9: The issue pipeline never holds more than one message, so `dir_valid` is never high on two consecutive cycles when ISSUE_LAT is at least 1.
- R10: `rsp_ready` is always 1. Responses are consumed in the cycle they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Sequencer request present |
| req_ready | output | 1 | Request is consumed this cycle if valid |
| req_kind | input | 2 | 00 load, 01 store, others invalid |
| req_paddr | input | AW | Physical address |
| req_laddr | input | AW | Line address |
| req_data | input | DW | Data block |
| req_len | input | LW | Transfer length |
| dir_valid | output | 1 | Directory message strobe |
| dir_kind | output | 1 | 0 read, 1 write |
| dir_paddr | output | AW | Copied physical address |
| dir_laddr | output | AW | Copied line address |
| dir_src | output | IDW | Requester identity |
| dir_dest | output | DEST_W | Target directory index |
| dir_data | output | DW | Copied data block |
| dir_len | output | LW | Copied length |
| rsp_valid | input | 1 | Directory response present |
| rsp_ready | output | 1 | Response consumed |
| rsp_kind | input | 2 | 01 data, 10 acknowledge, others invalid |
| rsp_data | input | DW | Response data block |
| seq_data_valid | output | 1 | Read data strobe to sequencer |
| seq_data | output | DW | Read data to sequencer |
| seq_ack | output | 1 | Write completion strobe to sequencer |
| err_req | output | 1 | Sticky bad request type flag |
| err_rsp | output | 1 | Sticky unexpected response flag |

## Verification
The hardest case to reach is a response that comes in while a transaction is open but carries the type of the other busy state. From the ports this means opening a read, letting its message drain from the pipeline, then presenting an acknowledge. The bench must then confirm that the read is still open, through `req_ready` staying low, before a correct data response closes it. A second hard case is a request held valid for the whole busy window. The bench keeps it asserted across the full pipeline delay and the response, then counts directory strobes to show it never slipped through.

// File: rtl/dma_txn_pkg.sv
`timescale 1ns/1ps
package dma_txn_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_OPEN = 2'd1,
      ST_WR_OPEN = 2'd2
   } txn_state_e;

   localparam logic [1:0] REQ_LOAD  = 2'b00;
   localparam logic [1:0] REQ_STORE = 2'b01;
   localparam logic [1:0] RSP_DATA  = 2'b01;
   localparam logic [1:0] RSP_ACK   = 2'b10;
endpackage

// File: rtl/dma_kind_decode.sv
`timescale 1ns/1ps
module dma_kind_decode
   import dma_txn_pkg::*;
(
   input  logic [1:0] req_kind,
   input  logic [1:0] rsp_kind,
   output logic       req_is_load,
   output logic       req_is_store,
   output logic       req_is_bad,
   output logic       rsp_is_data,
   output logic       rsp_is_ack
);
   always_comb begin
      req_is_load  = (req_kind == REQ_LOAD);
      req_is_store = (req_kind == REQ_STORE);
      req_is_bad   = !(req_is_load || req_is_store);
      rsp_is_data  = (rsp_kind == RSP_DATA);
      rsp_is_ack   = (rsp_kind == RSP_ACK);
   end
endmodule

// File: rtl/dma_issue_pipe.sv
`timescale 1ns/1ps
module dma_issue_pipe #(
   parameter int W   = 8,
   parameter int LAT = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_msg,
   output logic         out_valid,
   output logic [W-1:0] out_msg,
   output logic         busy
);
   if (W < 1) begin : g_chk_w
      $error("dma_issue_pipe: W must be at least 1");
   end
   if (LAT < 0) begin : g_chk_lat
      $error("dma_issue_pipe: LAT must not be negative");
   end

   if (LAT == 0) begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = ^{clk, rst_n};
      assign out_valid = in_valid;
      assign out_msg   = in_msg;
      assign busy      = 1'b0;
   end else begin : g_chain
      logic [LAT-1:0] vld;
      logic [W-1:0]   dat [LAT];

      for (genvar s = 0; s < LAT; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) vld[0] <= 1'b0;
               else        vld[0] <= in_valid;
            end
            always_ff @(posedge clk) begin
               if (in_valid) dat[0] <= in_msg;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) vld[s] <= 1'b0;
               else        vld[s] <= vld[s-1];
            end
            always_ff @(posedge clk) begin
               if (vld[s-1]) dat[s] <= dat[s-1];
            end
         end
      end

      assign out_valid = vld[LAT-1];
      assign out_msg   = dat[LAT-1];
      assign busy      = |vld;
   end
endmodule

// File: rtl/dma_txn_fsm.sv
`timescale 1ns/1ps
module dma_txn_fsm
   import dma_txn_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_load,
   input  logic          acc_store,
   input  logic          acc_bad,
   input  logic          rsp_valid,
   input  logic          rsp_is_data,
   input  logic          rsp_is_ack,
   input  logic [DW-1:0] rsp_data,
   output logic          idle,
   output logic          seq_data_valid,
   output logic [DW-1:0] seq_data,
   output logic          seq_ack,
   output logic          err_req,
   output logic          err_rsp
);
   txn_state_e state_q;

   assign idle = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         seq_data_valid <= 1'b0;
         seq_data       <= '0;
         seq_ack        <= 1'b0;
         err_req        <= 1'b0;
         err_rsp        <= 1'b0;
      end else begin
         seq_data_valid <= 1'b0;
         seq_ack        <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (acc_load)       state_q <= ST_RD_OPEN;
               else if (acc_store) state_q <= ST_WR_OPEN;
               if (acc_bad)        err_req <= 1'b1;
               if (rsp_valid)      err_rsp <= 1'b1;
            end
            ST_RD_OPEN: begin
               if (rsp_valid) begin
                  if (rsp_is_data) begin
                     state_q        <= ST_IDLE;
                     seq_data_valid <= 1'b1;
                     seq_data       <= rsp_data;
                  end else begin
                     err_rsp <= 1'b1;
                  end
               end
            end
            ST_WR_OPEN: begin
               if (rsp_valid) begin
                  if (rsp_is_ack) begin
                     state_q <= ST_IDLE;
                     seq_ack <= 1'b1;
                  end else begin
                     err_rsp <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_txn_ctrl.sv
`timescale 1ns/1ps
module dma_txn_ctrl #(
   parameter int AW        = 32,
   parameter int DW        = 64,
   parameter int LW        = 8,
   parameter int IDW       = 4,
   parameter int REQ_ID    = 5,
   parameter int NUM_DIRS  = 4,
   parameter int DIR_LSB   = 6,
   parameter int ISSUE_LAT = 6,
   localparam int DEST_W   = (NUM_DIRS > 1) ? $clog2(NUM_DIRS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [AW-1:0]     req_paddr,
   input  logic [AW-1:0]     req_laddr,
   input  logic [DW-1:0]     req_data,
   input  logic [LW-1:0]     req_len,
   output logic              dir_valid,
   output logic              dir_kind,
   output logic [AW-1:0]     dir_paddr,
   output logic [AW-1:0]     dir_laddr,
   output logic [IDW-1:0]    dir_src,
   output logic [DEST_W-1:0] dir_dest,
   output logic [DW-1:0]     dir_data,
   output logic [LW-1:0]     dir_len,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [1:0]        rsp_kind,
   input  logic [DW-1:0]     rsp_data,
   output logic              seq_data_valid,
   output logic [DW-1:0]     seq_data,
   output logic              seq_ack,
   output logic              err_req,
   output logic              err_rsp
);
   localparam int MW = 1 + 2*AW + IDW + DEST_W + DW + LW;

   if (AW < 1 || DW < 1 || LW < 1 || IDW < 1) begin : g_chk_widths
      $error("dma_txn_ctrl: all widths must be positive");
   end
   if (NUM_DIRS < 1) begin : g_chk_dirs
      $error("dma_txn_ctrl: NUM_DIRS must be at least 1");
   end
   if (DIR_LSB < 0 || DIR_LSB + DEST_W > AW) begin : g_chk_slice
      $error("dma_txn_ctrl: directory select slice leaves the address");
   end
   if (REQ_ID < 0 || REQ_ID >= (1 << IDW)) begin : g_chk_id
      $error("dma_txn_ctrl: REQ_ID does not fit IDW bits");
   end
   if (ISSUE_LAT < 0) begin : g_chk_lat
      $error("dma_txn_ctrl: ISSUE_LAT must not be negative");
   end

   logic req_is_load, req_is_store, req_is_bad;
   logic rsp_is_data, rsp_is_ack;
   logic idle, pipe_busy, accept;
   logic [DEST_W-1:0] dest_sel;
   logic [MW-1:0] msg_in, msg_out;

   dma_kind_decode u_dec (
      .req_kind     (req_kind),
      .rsp_kind     (rsp_kind),
      .req_is_load  (req_is_load),
      .req_is_store (req_is_store),
      .req_is_bad   (req_is_bad),
      .rsp_is_data  (rsp_is_data),
      .rsp_is_ack   (rsp_is_ack)
   );

   assign req_ready = idle && !pipe_busy;
   assign rsp_ready = 1'b1;
   assign accept    = req_valid && req_ready;

   if (NUM_DIRS > 1) begin : g_dest_slice
      assign dest_sel = req_laddr[DIR_LSB +: DEST_W];
   end else begin : g_dest_single
      assign dest_sel = '0;
   end

   assign msg_in = {req_is_store, req_paddr, req_laddr, IDW'(REQ_ID),
                    dest_sel, req_data, req_len};

   dma_issue_pipe #(
      .W   (MW),
      .LAT (ISSUE_LAT)
   ) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (accept && !req_is_bad),
      .in_msg    (msg_in),
      .out_valid (dir_valid),
      .out_msg   (msg_out),
      .busy      (pipe_busy)
   );

   assign {dir_kind, dir_paddr, dir_laddr, dir_src,
           dir_dest, dir_data, dir_len} = msg_out;

   dma_txn_fsm #(
      .DW (DW)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_load       (accept && req_is_load),
      .acc_store      (accept && req_is_store),
      .acc_bad        (accept && req_is_bad),
      .rsp_valid      (rsp_valid),
      .rsp_is_data    (rsp_is_data),
      .rsp_is_ack     (rsp_is_ack),
      .rsp_data       (rsp_data),
      .idle           (idle),
      .seq_data_valid (seq_data_valid),
      .seq_data       (seq_data),
      .seq_ack        (seq_ack),
      .err_req        (err_req),
      .err_rsp        (err_rsp)
   );
endmodule

// File: rtl/dma_txn_ctrl_chk.sv
`timescale 1ns/1ps
module dma_txn_ctrl_chk #(
   parameter int ISSUE_LAT = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       dir_valid,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [1:0] rsp_kind,
   input logic       seq_data_valid,
   input logic       seq_ack,
   input logic       err_req,
   input logic       err_rsp
);
   a_r10_rsp_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready);

   a_r5_data_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      seq_data_valid |-> $past(rsp_valid && rsp_kind == 2'b01));

   a_r6_ack_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ack |-> $past(rsp_valid && rsp_kind == 2'b10));

   a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_data_valid && seq_ack));

   a_r7_err_rsp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_rsp |=> err_rsp);

   a_r8_err_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_req |=> err_req);

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (ISSUE_LAT > 0 && dir_valid) |=> !dir_valid);

   a_r4_no_take_while_issuing: assert property (@(posedge clk) disable iff (!rst_n)
      (ISSUE_LAT > 0 && dir_valid) |-> !req_ready);

   a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !rsp_valid) |=> !req_ready);
endmodule

bind dma_txn_ctrl dma_txn_ctrl_chk #(.ISSUE_LAT(ISSUE_LAT)) u_chk (.*);

// File: tb/dma_txn_ctrl_tb.sv
`timescale 1ns/1ps
module dma_txn_ctrl_tb;
   localparam int AW = 32, DW = 64, LW = 8, IDW = 4;
   localparam int REQ_ID = 5, NUM_DIRS = 4, DIR_LSB = 6, LAT = 6;
   localparam int DEST_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_kind = '0;
   logic [AW-1:0] req_paddr = '0, req_laddr = '0;
   logic [DW-1:0] req_data = '0;
   logic [LW-1:0] req_len = '0;
   logic dir_valid, dir_kind;
   logic [AW-1:0] dir_paddr, dir_laddr;
   logic [IDW-1:0] dir_src;
   logic [DEST_W-1:0] dir_dest;
   logic [DW-1:0] dir_data;
   logic [LW-1:0] dir_len;
   logic rsp_valid = 1'b0;
   logic rsp_ready;
   logic [1:0] rsp_kind = '0;
   logic [DW-1:0] rsp_data = '0;
   logic seq_data_valid, seq_ack, err_req, err_rsp;
   logic [DW-1:0] seq_data;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   dma_txn_ctrl #(
      .AW(AW), .DW(DW), .LW(LW), .IDW(IDW), .REQ_ID(REQ_ID),
      .NUM_DIRS(NUM_DIRS), .DIR_LSB(DIR_LSB), .ISSUE_LAT(LAT)
   ) u_dut (.*);

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drive_req(input logic [1:0] k, input logic [AW-1:0] pa, la,
                            input logic [DW-1:0] d, input logic [LW-1:0] ln);
      req_valid = 1'b1; req_kind = k; req_paddr = pa;
      req_laddr = la; req_data = d; req_len = ln;
   endtask

   // Issue one load or store and check the directory message timing and fields.
   task automatic issue_and_check(input string rq, input logic [1:0] k,
                                  input logic [AW-1:0] pa, la,
                                  input logic [DW-1:0] d, input logic [LW-1:0] ln);
      chk("R1", "req_ready before issue", req_ready, 1);
      drive_req(k, pa, la, d, ln);
      for (int i = 1; i <= LAT; i++) begin
         @(negedge clk);
         if (i == 1) begin
            req_valid = 1'b0;
            chk("R4", "req_ready while open", req_ready, 0);
         end
         if (i == LAT - 1) chk(rq, "dir_valid early", dir_valid, 0);
      end
      chk(rq, "dir_valid", dir_valid, 1);
      chk(rq, "dir_kind", dir_kind, (k == 2'b01));
      chk(rq, "dir_paddr", dir_paddr, pa);
      chk(rq, "dir_laddr", dir_laddr, la);
      chk(rq, "dir_data", dir_data, d);
      chk(rq, "dir_len", dir_len, ln);
      chk(rq, "dir_src", dir_src, REQ_ID);
      chk(rq, "dir_dest", dir_dest, la[DIR_LSB +: DEST_W]);
      @(negedge clk);
      chk("R9", "dir_valid single cycle", dir_valid, 0);
   endtask

   task automatic respond(input logic [1:0] k, input logic [DW-1:0] d);
      rsp_valid = 1'b1; rsp_kind = k; rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "dir_valid", dir_valid, 0);
      chk("R1", "seq_data_valid", seq_data_valid, 0);
      chk("R1", "seq_ack", seq_ack, 0);
      chk("R1", "err flags", {err_req, err_rsp}, 0);
      chk("R10", "rsp_ready", rsp_ready, 1);
   endtask

   task automatic t_read(input logic [AW-1:0] pa, la, input logic [DW-1:0] d,
                         input logic [LW-1:0] ln, input logic [DW-1:0] rd);
      issue_and_check("R2", 2'b00, pa, la, d, ln);
      respond(2'b01, rd);
      chk("R5", "seq_data_valid", seq_data_valid, 1);
      chk("R5", "seq_data", seq_data, rd);
      chk("R5", "no ack", seq_ack, 0);
      @(negedge clk);
      chk("R5", "strobe single", seq_data_valid, 0);
      chk("R5", "ready again", req_ready, 1);
      chk("R7", "no error", err_rsp, 0);
   endtask

   task automatic t_write(input logic [AW-1:0] pa, la, input logic [DW-1:0] d,
                          input logic [LW-1:0] ln);
      issue_and_check("R3", 2'b01, pa, la, d, ln);
      respond(2'b10, '0);
      chk("R6", "seq_ack", seq_ack, 1);
      chk("R6", "no data strobe", seq_data_valid, 0);
      @(negedge clk);
      chk("R6", "ack single", seq_ack, 0);
      chk("R6", "ready again", req_ready, 1);
   endtask

   // A request held valid through a whole write must never be taken.
   task automatic t_stall();
      int pulses = 0;
      do_reset();
      drive_req(2'b01, 32'h1000, 32'h1040, 64'hAA, 8'd4);
      @(negedge clk);
      drive_req(2'b00, 32'h2000, 32'h2080, 64'hBB, 8'd8);
      for (int i = 0; i < LAT + 3; i++) begin
         if (dir_valid) pulses++;
         chk("R4", "ready low while held", req_ready, 0);
         @(negedge clk);
      end
      rsp_valid = 1'b1; rsp_kind = 2'b10;
      req_valid = 1'b0;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R6", "ack after stall", seq_ack, 1);
      for (int i = 0; i < LAT + 2; i++) begin
         if (dir_valid) pulses++;
         @(negedge clk);
      end
      chk("R4", "directory messages", pulses, 1);
   endtask

   task automatic t_mismatch();
      do_reset();
      issue_and_check("R2", 2'b00, 32'h3000, 32'h30C0, 64'h11, 8'd2);
      respond(2'b10, '0);
      chk("R7", "err_rsp on wrong ack", err_rsp, 1);
      chk("R7", "no ack strobe", seq_ack, 0);
      chk("R7", "still open", req_ready, 0);
      respond(2'b01, 64'hCAFE);
      chk("R5", "read closes after error", seq_data_valid, 1);
      chk("R5", "data", seq_data, 64'hCAFE);
      @(negedge clk);
      chk("R7", "err_rsp sticky", err_rsp, 1);

      do_reset();
      respond(2'b01, 64'h77);
      chk("R7", "err_rsp on idle response", err_rsp, 1);
      chk("R7", "no data strobe idle", seq_data_valid, 0);
      chk("R7", "still idle", req_ready, 1);

      do_reset();
      issue_and_check("R3", 2'b01, 32'h4000, 32'h4000, 64'h22, 8'd1);
      respond(2'b11, '0);
      chk("R7", "err_rsp on bad kind", err_rsp, 1);
      chk("R7", "write still open", req_ready, 0);
      respond(2'b01, 64'h5);
      chk("R7", "data in write open ignored", seq_data_valid, 0);
      respond(2'b10, '0);
      chk("R6", "write closes", seq_ack, 1);
   endtask

   task automatic t_bad_req();
      int pulses = 0;
      do_reset();
      drive_req(2'b10, 32'h5000, 32'h5040, 64'h33, 8'd3);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8", "err_req set", err_req, 1);
      chk("R8", "stays idle", req_ready, 1);
      for (int i = 0; i < LAT + 2; i++) begin
         if (dir_valid) pulses++;
         @(negedge clk);
      end
      chk("R8", "no directory message", pulses, 0);
      drive_req(2'b11, 32'h5000, 32'h5040, 64'h33, 8'd3);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8", "err_req sticky", err_req, 1);
      chk("R8", "err_rsp untouched", err_rsp, 0);
   endtask

   initial begin
      t_reset();
      t_read(32'h0000_1234, 32'h0000_1200, 64'h0123_4567_89AB_CDEF, 8'd64, 64'hDEAD_BEEF);
      t_read(32'hFFFF_FFC0, 32'hFFFF_FFC0, 64'h0, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      t_write(32'h8000_0040, 32'h8000_0040, 64'h5555_AAAA_5555_AAAA, 8'd32);
      t_write(32'h0000_00C0, 32'h0000_00C0, 64'h1, 8'hFF);
      t_stall();
      t_mismatch();
      t_bad_req();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule